// File: doc/BRIEF.md
# Stereo Automatic Level Control Gain Engine

This block sets the gain of a stereo stream of signed samples, one sample pair at a time. A peak tracker follows the larger magnitude of the two channels. It rises at once to any larger sample and otherwise falls by a fraction set by a three-bit fall-rate field. The tracked peak is compared against a programmed target. A peak above the target lowers the gain code one step at a time, at a programmed attack pace. A peak below the target raises the gain after a programmed hold period, at a programmed decay pace. A peak equal to the target leaves the gain alone.

The gain is a six-bit code in 1.5 dB steps, with code 51 meaning unity. It is capped by a programmed maximum. A limiter-only setting caps it at unity as well, so the block can then only attenuate and release. A noise gate freezes every gain decision while the tracked peak lies below a programmed floor, so that quiet background noise cannot pump the gain upward. Both channels share the one gain code, and the gained samples appear one clock after each accepted input.

Top module: `alc_gain_engine`

## Requirements
- R1: After reset, gain_code is 51, out_valid is 0, and both output samples are 0.
- R2: For each accepted sample (in_valid high), out_valid is 1 in the next cycle. Each output channel then equals sat(floor(x * M[r] * 2^q / 2^21)), where x is that channel's input, g is the gain code in force before the sample, q = (g+1)>>2, r = (g+1)&3, and M = {256, 304, 362, 431}. Code 51 therefore passes samples unchanged.
- R3: The tracked peak becomes the larger of max(|left|,|right|) and peak - (peak >> (fall+2)), where fall is cfg_peak_fall. All gain decisions for a sample use this updated peak.
- R4: The threshold is (cfg_target+1) * 2^(DATA_W-6). While the peak is above the threshold, the gain code drops by one on every (cfg_attack+1)-th consecutive loud sample and never goes below 0. A peak exactly at the threshold changes nothing.
- R5: While the peak is below the threshold, the first cfg_hold quiet samples only wait. After that, the gain code rises by one on every (cfg_decay+1)-th quiet sample. Any loud or matching sample restarts the hold.
- R6: The gain code never rises above cfg_max_gain. If it is above that ceiling, the next accepted sample sets it to the ceiling.
- R7: With cfg_limit_only set, the ceiling is min(51, cfg_max_gain). Attenuation still works in this mode.
- R8: With cfg_gate_en set and the peak below (cfg_gate_floor+1) * 2^(DATA_W-10), the sample leaves the gain and its hold and rate counters unchanged.
- R9: Cycles with in_valid low change neither the gain nor the peak, and do not raise out_valid.
- R10: Gained results outside the signed DATA_W range clamp to the largest or smallest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| cfg_target | input | 5 | Target level code |
| cfg_attack | input | CNT_W | Loud samples per gain step down, minus one |
| cfg_decay | input | CNT_W | Quiet samples per gain step up, minus one |
| cfg_hold | input | CNT_W | Quiet samples to wait before rising |
| cfg_max_gain | input | 6 | Highest permitted gain code |
| cfg_limit_only | input | 1 | Cap gain at unity |
| cfg_gate_en | input | 1 | Enable noise gate |
| cfg_gate_floor | input | 4 | Noise floor code |
| cfg_peak_fall | input | 3 | Peak fall-rate code |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | DATA_W | Gained left sample |
| out_right | output | DATA_W | Gained right sample |
| gain_code | output | 6 | Current gain code |

## Verification
A loud burst followed by silence walks the gain down at the attack pace, through the hold period, and back up again. This shows that the attack, hold and decay counts are applied separately and that the peak falls gradually rather than at once. Constant samples exactly at the threshold separate "above" from "at or above". Silence from reset, under different hold, decay, maximum and limiter settings, separates the hold period from the decay pace and the two ceilings from each other. A sample between the gate floor and the target, followed by silence, shows that the gate acts only below the floor. Two runs that differ only in fall rate show the peak fall rate at work. Samples at the top gain code separate the saturated results from the in-range ones, and a long loud run pins the bottom code.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int GAIN_W = 6;
  localparam logic [GAIN_W-1:0] UNITY_CODE = 6'd51;
  localparam int MANT_W = 10;
  localparam int MANT_FRAC = 8;
  localparam int OCT_BIAS = 13;
  localparam int OCT_MAX = 16;

  typedef enum logic [1:0] {
    LVL_QUIET = 2'd0,
    LVL_MATCH = 2'd1,
    LVL_LOUD  = 2'd2,
    LVL_GATED = 2'd3
  } lvl_e;

  // quarter-octave mantissa, 2^(k/4) scaled by 2^MANT_FRAC
  function automatic logic [MANT_W-1:0] step_mant(input logic [1:0] sub);
    case (sub)
      2'd0:    step_mant = 10'd256;
      2'd1:    step_mant = 10'd304;
      2'd2:    step_mant = 10'd362;
      default: step_mant = 10'd431;
    endcase
  endfunction
endpackage

// File: rtl/alc_peak_tracker.sv
module alc_peak_tracker #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_l,
  input  logic signed [DATA_W-1:0] smp_r,
  input  logic [2:0]               cfg_peak_fall,
  output logic [DATA_W-1:0]        peak_nxt
);
  logic [DATA_W-1:0] mag_l, mag_r, mag_max, decayed, peak_q, peak_d;
  logic [4:0]        shamt;

  always_comb begin
    mag_l   = smp_l[DATA_W-1] ? $unsigned(-smp_l) : $unsigned(smp_l);
    mag_r   = smp_r[DATA_W-1] ? $unsigned(-smp_r) : $unsigned(smp_r);
    mag_max = (mag_l > mag_r) ? mag_l : mag_r;
    shamt   = {2'b00, cfg_peak_fall} + 5'd2;
    decayed = peak_q - (peak_q >> shamt);
    peak_nxt = (mag_max > decayed) ? mag_max : decayed;
    peak_d  = smp_valid ? peak_nxt : peak_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) peak_q <= '0;
    else        peak_q <= peak_d;
  end

  assert_peak_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> peak_q >= $past(mag_max));
  assert_peak_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(peak_q));
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] peak_nxt,
  input  logic [4:0]        cfg_target,
  input  logic [CNT_W-1:0]  cfg_attack,
  input  logic [CNT_W-1:0]  cfg_decay,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [GAIN_W-1:0] cfg_max_gain,
  input  logic              cfg_limit_only,
  input  logic              cfg_gate_en,
  input  logic [3:0]        cfg_gate_floor,
  output logic [GAIN_W-1:0] gain_q
);
  localparam int TGT_SH = DATA_W - 6;
  localparam int FLR_SH = DATA_W - 10;

  logic [DATA_W:0]    tgt_thr, flr_thr, pk;
  logic [GAIN_W-1:0]  ceil_code, gain_d;
  logic [CNT_W-1:0]   att_q, att_d, hold_q, hold_d, dec_q, dec_d;
  lvl_e               cls;

  assign tgt_thr = ((DATA_W+1)'(cfg_target) + (DATA_W+1)'(1)) << TGT_SH;
  assign flr_thr = ((DATA_W+1)'(cfg_gate_floor) + (DATA_W+1)'(1)) << FLR_SH;
  assign pk      = {1'b0, peak_nxt};
  assign ceil_code = (cfg_limit_only && (cfg_max_gain > UNITY_CODE)) ? UNITY_CODE
                                                                      : cfg_max_gain;

  always_comb begin
    if (cfg_gate_en && (pk < flr_thr)) cls = LVL_GATED;
    else if (pk > tgt_thr)             cls = LVL_LOUD;
    else if (pk < tgt_thr)             cls = LVL_QUIET;
    else                               cls = LVL_MATCH;
  end

  always_comb begin
    gain_d = gain_q;
    att_d  = att_q;
    hold_d = hold_q;
    dec_d  = dec_q;
    if (smp_valid) begin
      if (gain_q > ceil_code) begin
        gain_d = ceil_code;
        att_d  = '0;
        hold_d = '0;
        dec_d  = '0;
      end else begin
        case (cls)
          LVL_LOUD: begin
            hold_d = '0;
            dec_d  = '0;
            if (att_q >= cfg_attack) begin
              att_d = '0;
              if (gain_q != '0) gain_d = gain_q - 1'b1;
            end else begin
              att_d = att_q + 1'b1;
            end
          end
          LVL_QUIET: begin
            att_d = '0;
            if (hold_q < cfg_hold) begin
              hold_d = hold_q + 1'b1;
            end else if (dec_q >= cfg_decay) begin
              dec_d = '0;
              if (gain_q < ceil_code) gain_d = gain_q + 1'b1;
            end else begin
              dec_d = dec_q + 1'b1;
            end
          end
          LVL_MATCH: begin
            att_d  = '0;
            hold_d = '0;
            dec_d  = '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= UNITY_CODE;
      att_q  <= '0;
      hold_q <= '0;
      dec_q  <= '0;
    end else begin
      gain_q <= gain_d;
      att_q  <= att_d;
      hold_q <= hold_d;
      dec_q  <= dec_d;
    end
  end

  assert_loud_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (gain_q <= ceil_code) && (cls == LVL_LOUD)
    |=> (gain_q == $past(gain_q)) || (gain_q == $past(gain_q) - 1'b1));
  assert_quiet_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (gain_q <= ceil_code) && (cls == LVL_QUIET) |=> gain_q >= $past(gain_q));
  assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> gain_q <= $past(cfg_max_gain));
  assert_limiter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && cfg_limit_only |=> gain_q <= UNITY_CODE);
  assert_gate_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (gain_q <= ceil_code) && (cls == LVL_GATED) |=> $stable(gain_q));
  assert_gain_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(gain_q));
endmodule

// File: rtl/alc_gain_apply.sv
module alc_gain_apply
  import alc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] smp_in,
  input  logic [GAIN_W-1:0]        code,
  output logic signed [DATA_W-1:0] smp_out
);
  localparam int PW   = DATA_W + MANT_W + 1;
  localparam int EW   = PW + OCT_MAX;
  localparam int FRAC = MANT_FRAC + OCT_BIAS;
  localparam logic signed [EW-1:0] MAX_V = (EW'(1) <<< (DATA_W-1)) - EW'(1);
  localparam logic signed [EW-1:0] MIN_V = -(EW'(1) <<< (DATA_W-1));

  logic [GAIN_W:0]          code_p1;
  logic [GAIN_W-2:0]        oct;
  logic [1:0]               sub;
  logic signed [PW-1:0]     prod;
  logic signed [EW-1:0]     wide, scaled;

  always_comb begin
    code_p1 = {1'b0, code} + (GAIN_W+1)'(1);
    oct     = code_p1[GAIN_W:2];
    sub     = code_p1[1:0];
    prod    = PW'(smp_in) * PW'($signed({1'b0, step_mant(sub)}));
    wide    = EW'(prod) <<< oct;
    scaled  = wide >>> FRAC;
    if (scaled > MAX_V)      smp_out = MAX_V[DATA_W-1:0];
    else if (scaled < MIN_V) smp_out = MIN_V[DATA_W-1:0];
    else                     smp_out = scaled[DATA_W-1:0];
  end
endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
  import alc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic [4:0]               cfg_target,
  input  logic [CNT_W-1:0]         cfg_attack,
  input  logic [CNT_W-1:0]         cfg_decay,
  input  logic [CNT_W-1:0]         cfg_hold,
  input  logic [5:0]               cfg_max_gain,
  input  logic                     cfg_limit_only,
  input  logic                     cfg_gate_en,
  input  logic [3:0]               cfg_gate_floor,
  input  logic [2:0]               cfg_peak_fall,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic [5:0]               gain_code
);
  localparam int N_CH = 2;

  logic [1:0]               rst_pipe;
  logic                     rst_sync_n;
  logic [DATA_W-1:0]        peak_nxt;
  logic [GAIN_W-1:0]        gain_q;
  logic signed [DATA_W-1:0] ch_in  [N_CH];
  logic signed [DATA_W-1:0] ch_y   [N_CH];
  logic signed [DATA_W-1:0] out_q  [N_CH];
  logic signed [DATA_W-1:0] out_d  [N_CH];
  logic                     vld_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  alc_peak_tracker #(.DATA_W(DATA_W)) u_peak (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .smp_valid     (in_valid),
    .smp_l         (in_left),
    .smp_r         (in_right),
    .cfg_peak_fall (cfg_peak_fall),
    .peak_nxt      (peak_nxt)
  );

  alc_gain_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .smp_valid      (in_valid),
    .peak_nxt       (peak_nxt),
    .cfg_target     (cfg_target),
    .cfg_attack     (cfg_attack),
    .cfg_decay      (cfg_decay),
    .cfg_hold       (cfg_hold),
    .cfg_max_gain   (cfg_max_gain),
    .cfg_limit_only (cfg_limit_only),
    .cfg_gate_en    (cfg_gate_en),
    .cfg_gate_floor (cfg_gate_floor),
    .gain_q         (gain_q)
  );

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    alc_gain_apply #(.DATA_W(DATA_W)) u_apply (
      .smp_in  (ch_in[c]),
      .code    (gain_q),
      .smp_out (ch_y[c])
    );
    assign out_d[c] = in_valid ? ch_y[c] : out_q[c];
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) out_q[c] <= '0;
      else             out_q[c] <= out_d[c];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= in_valid;
  end

  assign out_valid = vld_q;
  assign out_left  = out_q[0];
  assign out_right = out_q[1];
  assign gain_code = gain_q;

  assert_unity_pass_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && (gain_code == UNITY_CODE) |=> (out_left == $past(in_left)) && out_valid);
  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
endmodule

// File: tb/alc_gain_engine_tb_top.sv
module alc_gain_engine_tb_top;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 5;
  localparam int N_VEC  = 13;
  // {sample, expected gain code after the sample}; target 7, attack 1, hold 2
  localparam logic [23:0] VEC [N_VEC] = '{
    {16'd20000, 8'd51}, {16'd20000, 8'd50}, {16'd20000, 8'd50}, {16'd20000, 8'd49},
    {16'd0, 8'd49}, {16'd0, 8'd48}, {16'd0, 8'd48}, {16'd0, 8'd48}, {16'd0, 8'd48},
    {16'd0, 8'd49}, {16'd0, 8'd50}, {16'd0, 8'd51}, {16'd0, 8'd52}
  };

  logic clk, rst_n, in_valid;
  logic signed [DATA_W-1:0] in_left, in_right, out_left, out_right;
  logic [4:0] cfg_target;
  logic [CNT_W-1:0] cfg_attack, cfg_decay, cfg_hold;
  logic [5:0] cfg_max_gain, gain_code;
  logic cfg_limit_only, cfg_gate_en, out_valid;
  logic [3:0] cfg_gate_floor;
  logic [2:0] cfg_peak_fall;

  int n_checks = 0;
  int n_fail = 0;
  int prev_gain;
  bit finished = 0;

  alc_gain_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .cfg_target(cfg_target), .cfg_attack(cfg_attack), .cfg_decay(cfg_decay),
    .cfg_hold(cfg_hold), .cfg_max_gain(cfg_max_gain), .cfg_limit_only(cfg_limit_only),
    .cfg_gate_en(cfg_gate_en), .cfg_gate_floor(cfg_gate_floor),
    .cfg_peak_fall(cfg_peak_fall), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .gain_code(gain_code)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  function automatic longint model_out(input longint x, input int code);
    longint mant, p;
    int q, r;
    q = (code + 1) >> 2;
    r = (code + 1) & 3;
    case (r)
      0: mant = 256;
      1: mant = 304;
      2: mant = 362;
      default: mant = 431;
    endcase
    p = (x * mant) <<< q;
    p = p >>> 21;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_default();
    cfg_target = 5'd7; cfg_attack = '0; cfg_decay = '0; cfg_hold = '0;
    cfg_max_gain = 6'd63; cfg_limit_only = 1'b0; cfg_gate_en = 1'b0;
    cfg_gate_floor = 4'd0; cfg_peak_fall = 3'd0;
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_left = '0; in_right = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic put(input int x, input int n);
    for (int k = 0; k < n; k++) begin
      prev_gain = int'(gain_code);
      in_left = DATA_W'(x); in_right = DATA_W'(-x); in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_default();
    do_reset();
    // R1 reset state
    chk("R1 gain", gain_code, 51);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_left", out_left, 0);
    chk("R1 out_right", out_right, 0);

    // table walk: R3 peak fall, R4 attack, R5 hold/decay, R2 gained output
    cfg_attack = 5'd1; cfg_hold = 5'd2;
    for (int i = 0; i < N_VEC; i++) begin
      int x;
      x = int'($signed(VEC[i][23:8]));
      put(x, 1);
      chk("R4/R5 table gain", gain_code, VEC[i][7:0]);
      chk("R2 left", out_left, model_out(x, prev_gain));
      chk("R2 right", out_right, model_out(-x, prev_gain));
      chk("R2 strobe", out_valid, 1);
    end

    // R9 idle cycles ignored
    cfg_default(); do_reset();
    in_left = 16'sd30000; in_right = 16'sd30000; in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 gain idle", gain_code, 51);
    chk("R9 no strobe", out_valid, 0);
    chk("R9 out held", out_left, 0);

    // R4 peak exactly at threshold
    put(8192, 5);
    chk("R4 match no change", gain_code, 51);

    // R4 attack pacing
    cfg_default(); do_reset(); cfg_attack = 5'd3;
    put(30000, 3); chk("R4 before step", gain_code, 51);
    put(30000, 1); chk("R4 first step", gain_code, 50);
    put(30000, 4); chk("R4 second step", gain_code, 49);

    // R5 hold then decay
    cfg_default(); do_reset(); cfg_hold = 5'd4; cfg_decay = 5'd2;
    put(0, 6); chk("R5 still holding", gain_code, 51);
    put(0, 1); chk("R5 first rise", gain_code, 52);
    put(0, 3); chk("R5 second rise", gain_code, 53);

    // R6 maximum level and clamp
    cfg_default(); do_reset(); cfg_max_gain = 6'd54;
    put(0, 10); chk("R6 ceiling", gain_code, 54);
    cfg_max_gain = 6'd52;
    put(0, 1); chk("R6 clamp", gain_code, 52);

    // R7 limiter
    cfg_default(); do_reset(); cfg_limit_only = 1'b1;
    put(0, 8); chk("R7 no boost", gain_code, 51);
    cfg_limit_only = 1'b0;
    put(0, 4); chk("R7 boost when off", gain_code, 55);
    cfg_limit_only = 1'b1;
    put(0, 1); chk("R7 clamp to unity", gain_code, 51);
    put(30000, 1); chk("R7 attenuates", gain_code, 50);

    // R8 noise gate
    cfg_default(); do_reset(); cfg_gate_en = 1'b1; cfg_gate_floor = 4'd15;
    put(0, 8); chk("R8 gated", gain_code, 51);
    cfg_gate_en = 1'b0;
    put(0, 1); chk("R8 gate off", gain_code, 52);
    cfg_gate_en = 1'b1;
    put(2000, 1); chk("R8 above floor", gain_code, 53);
    put(0, 3); chk("R8 falls under floor", gain_code, 55);
    put(0, 3); chk("R8 stays frozen", gain_code, 55);

    // R10 saturation at top code
    cfg_default(); do_reset();
    put(0, 12); chk("R6 top code", gain_code, 63);
    cfg_target = 5'd31;
    put(10000, 1);
    chk("R10 positive clamp", out_left, 32767);
    chk("R10 negative clamp", out_right, -32768);
    put(1000, 1);
    chk("R10 in range", out_left, 8000);

    // R4 bottom code
    cfg_default(); do_reset(); cfg_target = 5'd0;
    put(30000, 51); chk("R4 reaches zero", gain_code, 0);
    put(30000, 4); chk("R4 stays at zero", gain_code, 0);

    // R3 peak fall rate
    cfg_default(); do_reset(); cfg_attack = 5'd31; cfg_peak_fall = 3'd7;
    put(20000, 1); put(0, 5);
    chk("R3 slow fall", gain_code, 51);
    cfg_default(); do_reset(); cfg_attack = 5'd31; cfg_peak_fall = 3'd0;
    put(20000, 1); put(0, 5);
    chk("R3 fast fall", gain_code, 53);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule